// File: doc/BRIEF.md
# Sample FIFO with Token-Passing Serial Output

This block sits at the output of a measurement channel. Every finished 24-bit sample is joined with an 8-bit status byte to form a 32-bit word. The status byte carries a time-break mark, an overflow mark and six bits of channel status from upstream. Finished words wait in an eight-entry queue, so the collector on the telemetry side can be slow to fetch them without losing data.

The words leave on a three-wire serial link: an active-low ready line, a data clock and a data line. Several devices share that link in a daisy chain by passing a token. A device starts a transfer only when its token input is high. When it has sent one word, it releases ready and then raises its token output for the next device in the chain. Holding the token input high makes the block stream words on its own. Pulsing the token input fetches one word per pulse. A device with nothing queued passes the token straight on.

Top module: `tlm_sample_port`

## Requirements
- R1: The stored word is {sample[23:0], status[7:0]}. Status bit 7 is the time-break mark, bit 6 is the overflow mark and bits 5:0 are the channel status input. The word goes out most significant bit first, so sample bit 23 leads.
- R2: The queue holds DEPTH (8) words and sends them in arrival order. Every stored word is sent exactly once.
- R3: A transfer starts only at an idle cycle in which tok_in is high and the queue is non-empty. ready (rdy_n) goes low in the next cycle.
- R4: Each frame opens with HALF cycles of rdy_n low and sclk low. After that come 32 sclk high phases, separated by low phases. Every phase lasts HALF cycles. sclk is never high while rdy_n is high.
- R5: While rdy_n stays low, sdat changes only in the cycle where sclk falls. It therefore stays stable across each rising edge of sclk and through each high phase.
- R6: After the 32nd high phase, rdy_n is high for HALF cycles. Then tok_out is high for HALF cycles. tok_out is never high while rdy_n is low, nor in the cycle right after rdy_n rises.
- R7: If tok_in is seen while the queue is empty, rdy_n stays high and tok_out is high for HALF cycles, starting in the next cycle.
- R8: If tok_in is held high, frames follow one another with exactly one idle cycle after each token pulse.
- R9: A tbrk strobe sets status bit 7 in the next sample the queue accepts, including a sample accepted in the same cycle as the strobe. Later samples have the bit clear until the next strobe.
- R10: A sample that arrives while the queue is full is dropped. Status bit 6 is then set in the next word the queue accepts. A queue that is full at the start of a cycle stays closed to a new sample in that cycle, even if a word leaves in the same cycle.
- R11: After reset, rdy_n = 1, sclk = 0, sdat = 0, tok_out = 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A finished sample is presented this cycle |
| smp_data | input | 24 | Sample value |
| smp_user | input | 6 | Channel status bits placed in status bits 5:0 |
| tbrk | input | 1 | Time-break strobe |
| tok_in | input | 1 | Token from the previous device, or a request from the collector |
| rdy_n | output | 1 | Frame ready, active low |
| sclk | output | 1 | Serial data clock |
| sdat | output | 1 | Serial data, MSB first |
| tok_out | output | 1 | Token passed to the next device |

## Verification
The bench builds the block with DEPTH = 8 and HALF = 2. A complete frame then takes 132 cycles, so a dozen frames, a full queue and the dropped samples all fit in a short run. The short phase length also makes the frame edges close together, so an off-by-one in any phase timer shows up as a cycle mismatch against the model. The run covers forwarding from an empty queue, streaming while the token is held, fetching one word per token pulse, and pushes that land during a transfer.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int SAMPLE_W = 24;
  localparam int USER_W   = 6;
  localparam int STAT_W   = USER_W + 2;
  localparam int WORD_W   = SAMPLE_W + STAT_W;
  localparam int TB_POS   = STAT_W - 1;
  localparam int OVF_POS  = STAT_W - 2;

  typedef enum logic [2:0] {
    PS_IDLE, PS_LEAD, PS_HIGH, PS_LOW, PS_TRAIL, PS_TOKEN
  } port_state_e;

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [SAMPLE_W-1:0] smp,
    input logic                tb,
    input logic                ovf,
    input logic [USER_W-1:0]   usr
  );
    return {smp, tb, ovf, usr};
  endfunction
endpackage

// File: rtl/tsp_stamp.sv
module tsp_stamp
  import tsp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [USER_W-1:0]   smp_user,
  input  logic                tbrk,
  input  logic                full,
  output logic                push,
  output logic                drop,
  output logic [WORD_W-1:0]   word
);
  logic tb_pend, ovf_pend;

  assign push = smp_valid && !full;
  assign drop = smp_valid && full;
  assign word = pack_word(smp_data, tb_pend | tbrk, ovf_pend, smp_user);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_pend  <= 1'b0;
      ovf_pend <= 1'b0;
    end else if (push) begin
      tb_pend  <= 1'b0;
      ovf_pend <= 1'b0;
    end else begin
      if (tbrk) tb_pend  <= 1'b1;
      if (drop) ovf_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/tsp_fifo.sv
module tsp_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/tsp_serial.sv
module tsp_serial
  import tsp_pkg::*;
#(
  parameter int HALF = 4,
  parameter int W    = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tok_in,
  input  logic         empty,
  input  logic [W-1:0] head,
  output logic         pop,
  output logic         rdy_n,
  output logic         sclk,
  output logic         sdat,
  output logic         tok_out
);
  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = $clog2(W);
  localparam logic [TW-1:0] RELOAD = TW'(HALF - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(W - 1);

  port_state_e   st;
  logic [TW-1:0] tmr;
  logic [BW-1:0] bitn;
  logic [W-1:0]  shreg;
  logic          tdone, in_frame;

  assign tdone    = (tmr == '0);
  assign in_frame = (st == PS_LEAD) || (st == PS_HIGH) || (st == PS_LOW);
  assign pop      = (st == PS_IDLE) && tok_in && !empty;
  assign rdy_n    = !in_frame;
  assign sclk     = (st == PS_HIGH);
  assign sdat     = in_frame && shreg[W-1];
  assign tok_out  = (st == PS_TOKEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= PS_IDLE;
      tmr   <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else begin
      tmr <= tdone ? RELOAD : tmr - 1'b1;
      unique case (st)
        PS_IDLE: begin
          tmr  <= RELOAD;
          bitn <= '0;
          if (tok_in) begin
            if (!empty) begin
              shreg <= head;
              st    <= PS_LEAD;
            end else begin
              st <= PS_TOKEN;
            end
          end
        end
        PS_LEAD:  if (tdone) st <= PS_HIGH;
        PS_HIGH: begin
          if (tdone) begin
            if (bitn == LASTBIT) begin
              st <= PS_TRAIL;
            end else begin
              st    <= PS_LOW;
              shreg <= {shreg[W-2:0], 1'b0};
              bitn  <= bitn + 1'b1;
            end
          end
        end
        PS_LOW:   if (tdone) st <= PS_HIGH;
        PS_TRAIL: if (tdone) st <= PS_TOKEN;
        PS_TOKEN: if (tdone) st <= PS_IDLE;
        default:  st <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlm_sample_port.sv
module tlm_sample_port
  import tsp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int HALF  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [USER_W-1:0]   smp_user,
  input  logic                tbrk,
  input  logic                tok_in,
  output logic                rdy_n,
  output logic                sclk,
  output logic                sdat,
  output logic                tok_out
);
  logic              push_w, drop_w, pop_w, empty_w, full_w;
  logic [WORD_W-1:0] word_w, head_w;

  tsp_stamp u_stamp (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_user(smp_user), .tbrk(tbrk), .full(full_w),
    .push(push_w), .drop(drop_w), .word(word_w)
  );

  tsp_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_w), .din(word_w),
    .pop(pop_w), .dout(head_w), .empty(empty_w), .full(full_w)
  );

  tsp_serial #(.HALF(HALF), .W(WORD_W)) u_serial (
    .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .empty(empty_w), .head(head_w),
    .pop(pop_w), .rdy_n(rdy_n), .sclk(sclk), .sdat(sdat), .tok_out(tok_out)
  );
endmodule

// File: rtl/tlm_sample_port_chk.sv
module tlm_sample_port_chk (
  input logic clk,
  input logic rst_n,
  input logic rdy_n,
  input logic sclk,
  input logic sdat,
  input logic tok_out,
  input logic push,
  input logic drop,
  input logic pop,
  input logic full,
  input logic empty
);
  AST_TOKEN_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |-> (rdy_n && $past(rdy_n))); // R6
  AST_CLOCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !rdy_n); // R4
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && $past(!rdy_n) && !$stable(sdat)) |-> $fell(sclk)); // R5
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push); // R10
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> full); // R10
  AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop); // R2
  AST_READY_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(pop)); // R3
endmodule

bind tlm_sample_port tlm_sample_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n), .sclk(sclk), .sdat(sdat),
  .tok_out(tok_out), .push(push_w), .drop(drop_w), .pop(pop_w),
  .full(full_w), .empty(empty_w)
);

// File: tb/tb_tlm_sample_port.sv
module tb_tlm_sample_port;
  localparam int DEPTH = 8;
  localparam int H     = 2;
  localparam int FRAME = 66 * H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic [5:0]  smp_user = '0;
  logic        tbrk = 1'b0;
  logic        tok_in = 1'b0;
  logic        rdy_n, sclk, sdat, tok_out;

  tlm_sample_port #(.DEPTH(DEPTH), .HALF(H)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_user(smp_user), .tbrk(tbrk), .tok_in(tok_in),
    .rdy_n(rdy_n), .sclk(sclk), .sdat(sdat), .tok_out(tok_out)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // behavioural reference
  logic [31:0] mq[$];
  logic [31:0] sentq[$];
  bit          m_busy = 0, m_fwd = 0, tbp = 0, ovfp = 0;
  int          m_k = 0;
  logic [31:0] m_word = '0;

  // receiver
  logic [31:0] rx = '0;
  int rx_bits = 0, rx_cnt = 0, tb_seen = 0, ovf_seen = 0, fwd_cnt = 0, frames = 0;
  logic prev_sclk = 1'b0, prev_tok = 1'b0, prev_rdy = 1'b1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mq.delete(); sentq.delete();
      m_busy = 0; m_fwd = 0; m_k = 0; tbp = 0; ovfp = 0;
    end else begin
      automatic int sz = mq.size();
      if (!m_busy) begin
        if (tok_in) begin
          m_busy = 1; m_k = 0;
          if (sz > 0) begin
            m_word = mq.pop_front(); m_fwd = 0; sentq.push_back(m_word);
          end else m_fwd = 1;
        end
      end else begin
        m_k++;
        if (m_k == (m_fwd ? H : FRAME)) m_busy = 0;
      end
      if (smp_valid && sz < DEPTH) begin
        mq.push_back({smp_data, tbp | tbrk, ovfp, smp_user});
        tbp = 0; ovfp = 0;
      end else begin
        if (smp_valid) ovfp = 1;
        if (tbrk) tbp = 1;
      end
    end
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog: actual %0d received expected completion", rx_cnt);
      summary();
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic int  p = m_fwd ? 65 : m_k / H;
      automatic bit  e_rdy = !(m_busy && p <= 63);
      automatic bit  e_sclk = m_busy && p <= 63 && (p % 2 == 1);
      automatic bit  e_sdat = m_busy && p <= 63 && m_word[31 - p / 2];
      automatic bit  e_tok = m_busy && p == 65;
      check(rdy_n == e_rdy, "R3 R4 R8 rdy_n", 32'(rdy_n), 32'(e_rdy));
      check(sclk == e_sclk, "R4 sclk", 32'(sclk), 32'(e_sclk));
      check(sdat == e_sdat, "R1 R5 sdat", 32'(sdat), 32'(e_sdat));
      check(tok_out == e_tok, "R6 R7 tok_out", 32'(tok_out), 32'(e_tok));
      if (sclk && !prev_sclk) begin
        rx = {rx[30:0], sdat};
        rx_bits++;
        if (rx_bits == 32) begin
          automatic logic [31:0] ex = (sentq.size() > 0) ? sentq.pop_front() : 32'hx;
          check(rx === ex, "R1 R2 R9 R10 received word", rx, ex);
          if (rx[7]) tb_seen++;
          if (rx[6]) ovf_seen++;
          rx_cnt++; rx_bits = 0;
        end
      end
      if (!rdy_n && prev_rdy) frames++;
      if (tok_out && !prev_tok && rx_bits == 0 && frames == rx_cnt && !prev_frame_tail) fwd_cnt++;
      prev_sclk = sclk; prev_tok = tok_out; prev_rdy = rdy_n;
    end
  end

  // marks that the last frame ended recently, so a token pulse belongs to it
  bit prev_frame_tail = 0;
  int since_frame = 1000;
  always @(negedge clk) begin
    if (!rdy_n) since_frame = 0; else since_frame++;
    prev_frame_tail = (since_frame <= 2 * H);
  end

  task automatic push_s(input logic [23:0] d, input logic [5:0] u, input bit tb);
    @(negedge clk);
    smp_valid = 1; smp_data = d; smp_user = u; tbrk = tb;
    @(negedge clk);
    smp_valid = 0; tbrk = 0;
  endtask

  task automatic pulse_token();
    @(negedge clk); tok_in = 1;
    @(negedge clk); tok_in = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state at the ports
    check({rdy_n, sclk, sdat, tok_out} == 4'b1000, "R11 idle after reset",
          32'({rdy_n, sclk, sdat, tok_out}), 32'h8);

    // R7 token with empty queue is forwarded
    pulse_token();
    repeat (3 * H) @(negedge clk);
    check(fwd_cnt == 1, "R7 forwarded token count", 32'(fwd_cnt), 32'd1);
    check(frames == 0, "R7 no frame on empty queue", 32'(frames), 32'd0);

    // R9 time-break marks, R8 streaming with token held
    push_s(24'hA5C3F1, 6'h15, 1'b0);
    @(negedge clk); tbrk = 1; @(negedge clk); tbrk = 0;
    push_s(24'h123456, 6'h2A, 1'b0);
    push_s(24'h800001, 6'h01, 1'b1);
    push_s(24'h7FFFFE, 6'h3F, 1'b0);
    @(negedge clk); tok_in = 1;
    while (rx_cnt < 4) @(negedge clk);
    repeat (4 * H) @(negedge clk);
    tok_in = 0;
    check(tb_seen == 2, "R9 time-break marked words", 32'(tb_seen), 32'd2);

    // R10 overflow: eleven pushes into eight places
    repeat (3 * H) @(negedge clk);
    for (int i = 0; i < 11; i++) push_s(24'(i * 24'h010203 + 24'h00F00F), 6'(i), 1'b0);
    pulse_token();
    push_s(24'hCAFE01, 6'h22, 1'b0); // lands during a transfer
    while (rx_cnt < 5) @(negedge clk);
    repeat (4 * H) @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      pulse_token();
      while (rx_cnt < 6 + j) @(negedge clk);
      repeat (4 * H) @(negedge clk);
    end
    @(negedge clk); tok_in = 1;
    while (rx_cnt < 13) @(negedge clk);
    repeat (FRAME + 4 * H) @(negedge clk);
    tok_in = 0;
    check(ovf_seen == 1, "R10 overflow-marked words", 32'(ovf_seen), 32'd1);
    check(rx_cnt == 13, "R2 total words received", 32'(rx_cnt), 32'd13);
    check(sentq.size() == 0, "R2 no word left unsent", 32'(sentq.size()), 32'd0);
    repeat (4) @(negedge clk);
    finished = 1;
    summary();
  end
endmodule